// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block gathers the interrupt and error status of a group of DMA channels (sixteen by default) into two 32-bit status words and one combined interrupt line. Each channel delivers a one-cycle completion pulse, a one-cycle error pulse, and, with the error pulse, a flag that says whether the error was a bus fault (1) or an early termination (0). The block latches these events until software clears them.

The completion word carries the per-channel completion flags in bits 15:0 and the per-channel interrupt enables in bits 31:16. The error word carries the per-channel error flags in bits 15:0 and the per-channel error kind in bits 31:16. Software reaches both words over a small register bus. Each word can be written through a plain address, a set alias, or a clear alias. A fourth alias is read-only.

The block also produces a per-channel fault mask. An early termination on a channel that has also completed is treated as a normal finish, so it is left out of the mask.

Top module: `ias_irq_aggregator`

## Requirements
- R1: After reset, both status words read 0, `irq` is 0 and `fault_mask` is 0.
- R2: A `done_pulse[i]` sets completion flag bit i (completion word bit i) at the next clock edge. The flag holds until software clears it.
- R3: An `err_pulse[i]` sets error flag bit i of the error word at the next clock edge. In the same edge, bit 16+i takes the value of `err_is_bus[i]`: 1 for a bus fault, 0 for a termination.
- R4: A write with alias code 1 (`bus_addr[1:0]`=1) ORs `bus_wdata` into the selected word. Alias code 2 clears the bits that are 1 in `bus_wdata`. All other bits keep their value.
- R5: A write with alias code 0 replaces the whole selected word with `bus_wdata`. `bus_addr[2]` selects the word: 0 for the completion word, 1 for the error word.
- R6: When a hardware pulse and a software write reach the same bit in the same cycle, the hardware value wins. The flag ends set, and the error kind bit takes `err_is_bus`.
- R7: `irq` is 1 exactly when some channel has both its completion flag and its enable set, or when any error flag is set. `irq` follows the stored words without extra delay.
- R8: `fault_mask[i]` is 1 when error flag i is set and either the kind bit is 1 (bus fault) or completion flag i is 0.
- R9: `bus_rdata` returns the word selected by `bus_addr[2]` for every alias code, without waiting for a clock edge.
- R10: A write with alias code 3 changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Bit 2 selects the word; bits 1:0 select the alias (0 plain, 1 set, 2 clear, 3 read-only) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Content of the selected word |
| done_pulse | input | 16 | Per-channel completion event |
| err_pulse | input | 16 | Per-channel error event |
| err_is_bus | input | 16 | Error kind that comes with `err_pulse` (1 bus fault, 0 termination) |
| irq | output | 1 | Combined interrupt |
| fault_mask | output | 16 | Per-channel failure indication |

## Verification
The assertions run on every cycle and cover four things:
- A pulse always leaves its flag, and the matching kind bit, set after the next edge.
- The words do not move unless there is a bus write or a pulse.
- A read-only alias write changes nothing.
- Any error flag drives `irq`, and `fault_mask` never names a channel without an error flag.

The directed scenarios cover the rest:
- The exact word values after plain, set and clear writes.
- The interplay of enables and flags on `irq`.
- The rule that forgives a termination on a completed channel.
- A hardware pulse winning over a software clear or plain write issued in the same cycle.

// File: rtl/ias_pkg.sv
package ias_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ALIAS_PLAIN  = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLR    = 2'd2,
    ALIAS_MIRROR = 2'd3
  } alias_e;

endpackage

// File: rtl/ias_bus_decode.sv
module ias_bus_decode
  import ias_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output alias_e            op,
  output logic              comp_wen,
  output logic              err_wen,
  output logic              rd_err_sel
);

  logic write_live;

  always_comb begin
    op         = alias_e'(addr[1:0]);
    write_live = wr && (op != ALIAS_MIRROR);
    comp_wen   = write_live && !addr[2];
    err_wen    = write_live && addr[2];
    rd_err_sel = addr[2];
  end

endmodule

// File: rtl/ias_flag_reg.sv
module ias_flag_reg
  import ias_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_en,
  input  alias_e       sw_op,
  input  logic [W-1:0] sw_data,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] sw_apply(input logic [W-1:0] cur,
                                            input logic [W-1:0] data,
                                            input alias_e       op);
    case (op)
      ALIAS_PLAIN: return data;
      ALIAS_SET:   return cur | data;
      ALIAS_CLR:   return cur & ~data;
      default:     return cur;
    endcase
  endfunction

  logic [W-1:0] after_sw;
  logic [W-1:0] q_next;

  always_comb begin
    after_sw = sw_en ? sw_apply(q, sw_data, sw_op) : q;
    q_next   = (after_sw & ~hw_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/ias_irq_combine.sv
module ias_irq_combine #(
  parameter int NCH = 16,
  localparam int DW = 2 * NCH
) (
  input  logic [DW-1:0]  comp_q,
  input  logic [DW-1:0]  err_q,
  output logic           irq,
  output logic [NCH-1:0] fault_mask
);

  function automatic logic [NCH-1:0] fault_of(input logic [NCH-1:0] flag,
                                              input logic [NCH-1:0] kind,
                                              input logic [NCH-1:0] done);
    return flag & (kind | ~done);
  endfunction

  logic [NCH-1:0] done_flags;
  logic [NCH-1:0] done_enables;
  logic [NCH-1:0] err_flags;
  logic [NCH-1:0] err_kinds;
  logic [NCH-1:0] done_hits;

  always_comb begin
    done_flags   = comp_q[NCH-1:0];
    done_enables = comp_q[DW-1:NCH];
    err_flags    = err_q[NCH-1:0];
    err_kinds    = err_q[DW-1:NCH];
    done_hits    = done_flags & done_enables;
    irq          = (|done_hits) | (|err_flags);
    fault_mask   = fault_of(err_flags, err_kinds, done_flags);
  end

endmodule

// File: rtl/ias_irq_aggregator.sv
module ias_irq_aggregator
  import ias_pkg::*;
#(
  parameter int NCH = 16,
  localparam int DW = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    done_pulse,
  input  logic [NCH-1:0]    err_pulse,
  input  logic [NCH-1:0]    err_is_bus,
  output logic              irq,
  output logic [NCH-1:0]    fault_mask
);

  alias_e        wr_op;
  logic          comp_wen;
  logic          err_wen;
  logic          rd_err_sel;
  logic [DW-1:0] comp_q;
  logic [DW-1:0] err_q;
  logic [DW-1:0] comp_hw_set;
  logic [DW-1:0] comp_hw_clr;
  logic [DW-1:0] err_hw_set;
  logic [DW-1:0] err_hw_clr;

  ias_bus_decode u_dec (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .op         (wr_op),
    .comp_wen   (comp_wen),
    .err_wen    (err_wen),
    .rd_err_sel (rd_err_sel)
  );

  always_comb begin
    comp_hw_set = {{NCH{1'b0}}, done_pulse};
    comp_hw_clr = '0;
    err_hw_set  = {err_pulse & err_is_bus, err_pulse};
    err_hw_clr  = {err_pulse & ~err_is_bus, {NCH{1'b0}}};
  end

  ias_flag_reg #(.W(DW)) u_comp (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_en   (comp_wen),
    .sw_op   (wr_op),
    .sw_data (bus_wdata),
    .hw_set  (comp_hw_set),
    .hw_clr  (comp_hw_clr),
    .q       (comp_q)
  );

  ias_flag_reg #(.W(DW)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_en   (err_wen),
    .sw_op   (wr_op),
    .sw_data (bus_wdata),
    .hw_set  (err_hw_set),
    .hw_clr  (err_hw_clr),
    .q       (err_q)
  );

  ias_irq_combine #(.NCH(NCH)) u_comb (
    .comp_q     (comp_q),
    .err_q      (err_q),
    .irq        (irq),
    .fault_mask (fault_mask)
  );

  assign bus_rdata = rd_err_sel ? err_q : comp_q;

endmodule

// File: rtl/ias_checker.sv
module ias_checker #(
  parameter int NCH = 16,
  localparam int DW = 2 * NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     bus_addr,
  input logic           bus_wr,
  input logic [NCH-1:0] done_pulse,
  input logic [NCH-1:0] err_pulse,
  input logic [NCH-1:0] err_is_bus,
  input logic [DW-1:0]  comp_q,
  input logic [DW-1:0]  err_q,
  input logic           irq,
  input logic [NCH-1:0] fault_mask
);

  // R2
  done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_pulse) |=> ((comp_q[NCH-1:0] & $past(done_pulse)) == $past(done_pulse)));

  // R3
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> (((err_q[NCH-1:0] & $past(err_pulse)) == $past(err_pulse)) &&
                      ((err_q[DW-1:NCH] & $past(err_pulse)) == ($past(err_pulse) & $past(err_is_bus)))));

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !(|done_pulse) && !(|err_pulse)) |=> ($stable(comp_q) && $stable(err_q)));

  // R10
  mirror_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1:0] == 2'd3 && !(|done_pulse) && !(|err_pulse))
      |=> ($stable(comp_q) && $stable(err_q)));

  // R7
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q[NCH-1:0]) |-> irq);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(bus_wr) || $past(|done_pulse) || $past(|err_pulse)));

  // R8
  fault_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_mask) |-> ((fault_mask & ~err_q[NCH-1:0]) == '0));

endmodule

bind ias_irq_aggregator ias_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .done_pulse (done_pulse),
  .err_pulse  (err_pulse),
  .err_is_bus (err_is_bus),
  .comp_q     (comp_q),
  .err_q      (err_q),
  .irq        (irq),
  .fault_mask (fault_mask)
);

// File: tb/test_ias_irq_aggregator.sv
module test_ias_irq_aggregator;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW = 2 * NCH;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] done_pulse = '0;
  logic [NCH-1:0] err_pulse = '0;
  logic [NCH-1:0] err_is_bus = '0;
  logic           irq;
  logic [NCH-1:0] fault_mask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  ias_irq_aggregator #(.NCH(NCH)) i_ias_irq_aggregator (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .done_pulse (done_pulse),
    .err_pulse  (err_pulse),
    .err_is_bus (err_is_bus),
    .irq        (irq),
    .fault_mask (fault_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input logic [2:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_word(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    read_word(a, d);
    check(req, d, exp);
  endtask

  // One bus write plus optional pulses in the same cycle; returns just after the following negedge
  task automatic cycle(input logic wr, input logic [2:0] a, input logic [DW-1:0] d,
                       input logic [NCH-1:0] dp, input logic [NCH-1:0] ep, input logic [NCH-1:0] eb);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    done_pulse = dp; err_pulse = ep; err_is_bus = eb;
    @(negedge clk);
    bus_wr = 1'b0; done_pulse = '0; err_pulse = '0; err_is_bus = '0;
  endtask

  task automatic t_reset;
    check_word("R1 completion word", 3'b000, 32'h0);
    check_word("R1 error word", 3'b100, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 fault_mask", {16'b0, fault_mask}, 32'h0);
  endtask

  task automatic t_done_enable;
    cycle(1'b0, 3'b000, '0, 16'h0008, '0, '0);
    check_word("R2 flag latched", 3'b000, 32'h0000_0008);
    check("R7 no enable no irq", {31'b0, irq}, 32'h0);
    cycle(1'b1, 3'b001, 32'h0008_0000, '0, '0, '0);
    check_word("R4 set alias enable", 3'b000, 32'h0008_0008);
    check("R7 enabled flag irq", {31'b0, irq}, 32'h1);
    cycle(1'b1, 3'b010, 32'h0000_0008, '0, '0, '0);
    check_word("R4 clear alias flag", 3'b000, 32'h0008_0000);
    check("R7 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_errors;
    cycle(1'b0, 3'b000, '0, '0, 16'h0220, 16'h0020);
    check_word("R3 flags and kinds", 3'b100, 32'h0020_0220);
    check("R7 error irq", {31'b0, irq}, 32'h1);
    check("R8 both fail", {16'b0, fault_mask}, 32'h0000_0220);
    cycle(1'b0, 3'b000, '0, 16'h0200, '0, '0);
    check("R8 termination forgiven", {16'b0, fault_mask}, 32'h0000_0020);
    check_word("R2 second flag", 3'b000, 32'h0008_0200);
  endtask

  task automatic t_plain;
    cycle(1'b1, 3'b100, 32'h0, '0, '0, '0);
    check_word("R5 plain clears error word", 3'b100, 32'h0);
    check("R7 no hit irq low", {31'b0, irq}, 32'h0);
    cycle(1'b1, 3'b000, 32'h0001_0001, '0, '0, '0);
    check_word("R5 plain completion word", 3'b000, 32'h0001_0001);
    check("R7 irq from plain write", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_mirror;
    cycle(1'b1, 3'b011, 32'hFFFF_FFFF, '0, '0, '0);
    check_word("R10 mirror write ignored", 3'b000, 32'h0001_0001);
    cycle(1'b1, 3'b111, 32'hFFFF_FFFF, '0, '0, '0);
    check_word("R10 mirror write ignored err", 3'b100, 32'h0);
    check_word("R9 read set alias", 3'b001, 32'h0001_0001);
    check_word("R9 read clear alias", 3'b010, 32'h0001_0001);
    check_word("R9 read mirror alias", 3'b011, 32'h0001_0001);
  endtask

  task automatic t_race;
    cycle(1'b1, 3'b010, 32'h0000_0001, 16'h0001, '0, '0);
    check_word("R6 pulse beats clear", 3'b000, 32'h0001_0001);
    cycle(1'b1, 3'b110, 32'hFFFF_FFFF, '0, 16'h0004, 16'h0004);
    check_word("R6 error pulse beats clear", 3'b100, 32'h0004_0004);
    cycle(1'b1, 3'b100, 32'h0004_0000, '0, 16'h0004, 16'h0000);
    check_word("R6 kind from pulse over plain", 3'b100, 32'h0000_0004);
  endtask

  task automatic t_clear_all;
    cycle(1'b1, 3'b010, 32'hFFFF_FFFF, '0, '0, '0);
    cycle(1'b1, 3'b110, 32'hFFFF_FFFF, '0, '0, '0);
    check_word("R4 all cleared comp", 3'b000, 32'h0);
    check_word("R4 all cleared err", 3'b100, 32'h0);
    check("R7 irq low at end", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_done_enable();
    t_errors();
    t_plain();
    t_mirror();
    t_race();
    t_clear_all();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule